// File: doc/BRIEF.md
# Byte SPI master controller

This block is a processor-facing serial master that moves one byte per transfer in full duplex. Software configures it through a small register window (control, status, data and a select output), places a byte into the data register, and the block then generates eight serial clock pulses. It sends the byte on its serial output and gathers eight bits from its serial input at the same time. When the byte is done, the serial clock stops, a completion flag rises and an optional interrupt request follows.

The serial clock is derived from the system clock by a programmable divider with a double-speed setting, giving divisors from 2 to 128. The clock idles low, outgoing data is stable before each rising edge and changes on falling edges, and incoming data is captured on rising edges. Bit order is selectable. The transmit side holds a single byte, so a write during a shift is refused and flagged as a collision. The receive side has a read buffer that keeps the last finished byte while the next one shifts in. The peripheral select line is a plain software-written output; the block never drives it by itself.

Register window (addr): 0 = control, 1 = status, 2 = data, 3 = select. Reads return data combinationally from `addr`. Only a read strobe (`rd_en`) has side effects.

Top module: `spim_byte_ctrl`

## Requirements
- R1: A write to the data register (addr 2) while control bit 0 (enable) and bit 1 (master) are set and no transfer runs starts a transfer. The transfer produces exactly 8 rising edges on `sck`, and the 8 bits sampled from `miso` become readable at addr 2 once it ends.
- R2: `sck` idles low. `mosi` holds its first bit from the cycle after the starting write and changes only when `sck` falls. `miso` is captured on each rising edge of `sck`. `mosi` is 0 when idle.
- R3: Control bit 2 selects the bit order for both directions: 1 = least significant bit first, 0 = most significant bit first.
- R4: Control bits [5:4] (code) and bit 6 (double speed) set the divisor D. With bit 6 clear, codes 0..3 give D = 4, 16, 64 and 128. With bit 6 set they give D = 2, 8, 32 and 64. The completion flag is 0 for 8*D edges after the write edge and is 1 after edge 8*D+1.
- R5: Status bit 0 is the completion flag. `irq` is high while this flag and control bit 3 (interrupt enable) are both set.
- R6: A data register write during a transfer is refused. The running byte, its timing and its received value are unchanged, and status bit 1 (collision) is set.
- R7: The byte read at addr 2 is the last completed one. It stays readable while the next transfer shifts and is replaced only when that transfer completes.
- R8: Reading status (`rd_en` at addr 1) while a flag is set arms that flag. Any later data register access (read or write) clears the armed flags. A data access without a preceding status read leaves the flags set.
- R9: With enable or master clear, a data register write starts nothing: `sck` stays low and no flag is set.
- R10: `ss_n` follows bit 0 of the last write to addr 3, reads back at addr 3 bit 0, and is 1 after reset.
- R11: After reset, control and status read 0, and `sck`, `mosi` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Software-controlled peripheral select |
| irq | output | 1 | Completion interrupt request |

## Verification
Counting from the clock edge that accepts the data write, the completion flag and `irq` are due after edge 8*D+1. The bench therefore peeks status once at cycle 8*D, where it must still read 0, and once more one cycle later, where it must read 1. The sweep covers every divisor code in both speed settings and both bit orders. Register reads and `ss_n` are due combinationally or one edge after the strobe. The bench drives every strobe at the falling clock edge and reads back half a cycle later. The serial pins are judged per `sck` edge by a slave model that shifts `miso` on falling edges and records `mosi` on rising ones.

// File: rtl/spim_pkg.sv
// Shared constants and types for the byte SPI master.
// Assumes a byte-wide register window with four addresses.
package spim_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int MAX_HALF = 64;
    localparam int CNT_W    = $clog2(MAX_HALF);
    localparam int EDGE_W   = $clog2(2 * DATA_W);

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = ADDR_W'(0),
        ADR_STAT = ADDR_W'(1),
        ADR_DATA = ADDR_W'(2),
        ADR_SEL  = ADDR_W'(3)
    } addr_e;

    // Control register layout, most significant field first.
    typedef struct packed {
        logic       dbl;
        logic [1:0] rate;
        logic       irq_en;
        logic       lsb_first;
        logic       master;
        logic       enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Half serial period in system clocks, minus one, for a rate setting.
    function automatic logic [CNT_W-1:0] rate_half_m1(logic [1:0] rate, logic dbl);
        int div;
        div = (rate == 2'd3) ? 128 : (4 << (2 * int'(rate)));
        if (dbl) div = div / 2;
        return CNT_W'(div / 2 - 1);
    endfunction
endpackage

// File: rtl/spim_clkdiv.sv
// Half-period tick generator for the serial clock.
// Assumes half_m1 is stable while run is high.
module spim_clkdiv
    import spim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half_m1,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == half_m1);
    assign tick = run && wrap;

    // Count system clocks inside each half period; hold at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spim_shifter.sv
// One-byte full-duplex shift engine, serial clock idle low.
// Output bit is stable before each rising edge and moves on falling
// edges; input bit is captured on rising edges. Assumes start is never
// raised while busy and lsb_first is stable during a transfer.
module spim_shifter
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] load,
    input  logic              lsb_first,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx
);
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] tx_up, tx_dn, rx_up, rx_dn;
    logic [EDGE_W-1:0] edge_q;
    logic              busy_q, sck_q, done_q;
    logic              last_edge;

    // Next-value networks for both shift directions, one slice per bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == 0) begin : g_lo
            assign tx_up[i] = 1'b0;
            assign rx_up[i] = miso;
        end else begin : g_lo_mid
            assign tx_up[i] = tx_q[i-1];
            assign rx_up[i] = rx_q[i-1];
        end
        if (i == DATA_W - 1) begin : g_hi
            assign tx_dn[i] = 1'b0;
            assign rx_dn[i] = miso;
        end else begin : g_hi_mid
            assign tx_dn[i] = tx_q[i+1];
            assign rx_dn[i] = rx_q[i+1];
        end
    end

    assign last_edge = (edge_q == EDGE_W'(2 * DATA_W - 1));

    // Walk through the sixteen serial clock edges of one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
            edge_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                sck_q  <= 1'b0;
                edge_q <= '0;
                tx_q   <= load;
            end else if (busy_q && tick) begin
                edge_q <= edge_q + 1'b1;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= lsb_first ? rx_dn : rx_up;
                end else begin
                    sck_q <= 1'b0;
                    if (last_edge) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        tx_q <= lsb_first ? tx_dn : tx_up;
                    end
                end
            end
        end
    end

    assign busy = busy_q;
    assign sck  = sck_q;
    assign done = done_q;
    assign rx   = rx_q;
    assign mosi = busy_q && (lsb_first ? tx_q[0] : tx_q[DATA_W-1]);
endmodule

// File: rtl/spim_regs.sv
// Register window: control, status flags, read buffer and select output.
// Flags clear by a status read followed by any data register access.
// Assumes one strobe per cycle at a single address.
module spim_regs
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              start,
    output logic              lat_lsb,
    output logic [1:0]        lat_rate,
    output logic              lat_dbl,
    output logic              irq,
    output logic              ss_n
);
    ctrl_t             ctrl_q;
    logic              sel_q;
    logic              done_q, coll_q;
    logic              arm_done_q, arm_coll_q;
    logic [DATA_W-1:0] rbuf_q;
    logic              lsb_q, dbl_q;
    logic [1:0]        rate_q;
    logic              data_wr, data_acc, stat_rd, collide;

    assign data_wr  = wr_en && (addr == ADR_DATA);
    assign data_acc = (wr_en || rd_en) && (addr == ADR_DATA);
    assign stat_rd  = rd_en && (addr == ADR_STAT);
    assign start    = data_wr && ctrl_q.enable && ctrl_q.master && !busy;
    assign collide  = data_wr && busy;

    // Software-written control and select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sel_q  <= 1'b1;
        end else if (wr_en) begin
            if (addr == ADR_CTRL) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (addr == ADR_SEL)  sel_q  <= wdata[0];
        end
    end

    // Completion and collision flags with their two-step clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            coll_q     <= 1'b0;
            arm_done_q <= 1'b0;
            arm_coll_q <= 1'b0;
        end else begin
            if (xfer_done)                    done_q <= 1'b1;
            else if (data_acc && arm_done_q)  done_q <= 1'b0;
            if (collide)                      coll_q <= 1'b1;
            else if (data_acc && arm_coll_q)  coll_q <= 1'b0;
            if (stat_rd && done_q)            arm_done_q <= 1'b1;
            else if (data_acc)                arm_done_q <= 1'b0;
            if (stat_rd && coll_q)            arm_coll_q <= 1'b1;
            else if (data_acc)                arm_coll_q <= 1'b0;
        end
    end

    // Read buffer: takes the shifted-in byte when a transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf_q <= '0;
        end else if (xfer_done) begin
            rbuf_q <= rx_byte;
        end
    end

    // Freeze the order and rate for the duration of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsb_q  <= 1'b0;
            rate_q <= '0;
            dbl_q  <= 1'b0;
        end else if (start) begin
            lsb_q  <= ctrl_q.lsb_first;
            rate_q <= ctrl_q.rate;
            dbl_q  <= ctrl_q.dbl;
        end
    end

    // Read data selection by address.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: rdata = DATA_W'(ctrl_q);
            ADR_STAT: rdata = DATA_W'({coll_q, done_q});
            ADR_DATA: rdata = rbuf_q;
            ADR_SEL:  rdata = DATA_W'(sel_q);
            default:  rdata = '0;
        endcase
    end

    assign irq      = done_q && ctrl_q.irq_en;
    assign ss_n     = sel_q;
    assign lat_lsb  = lsb_q;
    assign lat_rate = rate_q;
    assign lat_dbl  = dbl_q;
endmodule

// File: rtl/spim_byte_ctrl.sv
// Top of the byte SPI master: register window, clock divider and
// shift engine. Assumes the select output is sequenced by software.
module spim_byte_ctrl
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n,
    output logic              irq
);
    logic              busy, xfer_done, start, tick;
    logic              lat_lsb, lat_dbl;
    logic [1:0]        lat_rate;
    logic [DATA_W-1:0] rx_byte;
    logic [CNT_W-1:0]  half_m1;

    assign half_m1 = rate_half_m1(lat_rate, lat_dbl);

    spim_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .busy      (busy),
        .xfer_done (xfer_done),
        .rx_byte   (rx_byte),
        .start     (start),
        .lat_lsb   (lat_lsb),
        .lat_rate  (lat_rate),
        .lat_dbl   (lat_dbl),
        .irq       (irq),
        .ss_n      (ss_n)
    );

    spim_clkdiv u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .half_m1 (half_m1),
        .tick    (tick)
    );

    spim_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load      (wdata),
        .lsb_first (lat_lsb),
        .tick      (tick),
        .miso      (miso),
        .busy      (busy),
        .sck       (sck),
        .mosi      (mosi),
        .done      (xfer_done),
        .rx        (rx_byte)
    );
endmodule

// File: rtl/spim_byte_ctrl_chk.sv
// Property checker for the byte SPI master, bound into the top.
// Assumes the synchronous active-low reset of the top.
module spim_byte_ctrl_chk
    import spim_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              sck,
    input logic              mosi,
    input logic              irq,
    input logic              ss_n,
    input logic              busy,
    input logic              xfer_done,
    input logic              start
);
    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && (addr == ADR_DATA))); // R1

    AST_DONE_ENDS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!busy && !sck)); // R1

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck); // R2

    AST_MOSI_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$fell(sck)) |-> $stable(mosi)); // R2

    AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R6

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(xfer_done) || $past(wr_en && (addr == ADR_CTRL)))); // R5

    AST_SEL_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == ADR_SEL)) |=> $stable(ss_n)); // R10
endmodule

bind spim_byte_ctrl spim_byte_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .sck       (sck),
    .mosi      (mosi),
    .irq       (irq),
    .ss_n      (ss_n),
    .busy      (busy),
    .xfer_done (xfer_done),
    .start     (start)
);

// File: tb/sim_spim_byte_ctrl.sv
// Self-checking bench: sweeps all rate codes, both speeds and both orders.
module sim_spim_byte_ctrl;
    logic       clk, rst_n, wr_en, rd_en, miso;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       sck, mosi, ss_n, irq;

    int n_chk = 0;
    int n_err = 0;

    // Slave model state
    logic [7:0] s_byte;
    bit         s_lsb;
    int         s_idx;
    logic [7:0] mseq;
    int         rises;

    spim_byte_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso),
        .ss_n(ss_n), .irq(irq)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Record the bit on mosi at each rising serial clock edge.
    always @(posedge sck) begin
        if (rises < 8) mseq[rises] = mosi;
        rises = rises + 1;
    end

    // Present the next slave bit after each falling serial clock edge.
    always @(negedge sck) begin
        s_idx = s_idx + 1;
        if (s_idx < 8) miso <= s_lsb ? s_byte[s_idx] : s_byte[7 - s_idx];
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic logic [7:0] mk_ctrl(bit lsb, int rate, bit dbl, bit ie);
        return {1'b0, dbl, 2'(rate), ie, lsb, 1'b1, 1'b1};
    endfunction

    function automatic int divisor(int rate, bit dbl);
        int d;
        d = (rate == 3) ? 128 : (4 << (2 * rate));
        return dbl ? d / 2 : d;
    endfunction

    task automatic clear_flags();
        logic [7:0] v;
        bus_rd(2'd1, v);
        bus_rd(2'd2, v);
        peek(2'd1, v);
        chk("R8 flags cleared", int'(v[1:0]), 0);
    endtask

    // One transfer with optional mid-way collision write and buffer peek.
    task automatic run_xfer(input logic [7:0] tx, input logic [7:0] sb, input bit lsb,
                            input int div, input bit exp_irq, input int coll_at,
                            input logic [7:0] coll_byte, input int rd_at,
                            input logic [7:0] rd_exp, input string tag);
        logic [7:0] v, eseq;
        s_byte = sb; s_lsb = lsb; s_idx = 0; rises = 0; mseq = '0;
        miso = lsb ? sb[0] : sb[7];
        bus_wr(2'd2, tx);
        for (int c = 1; c <= 8 * div; c++) begin
            @(posedge clk); @(negedge clk);
            wr_en = 1'b0;
            if (c == coll_at) begin
                addr = 2'd2; wdata = coll_byte; wr_en = 1'b1;
            end
            if (c == rd_at) begin
                peek(2'd2, v);
                chk({tag, " R7 old byte held during shift"}, int'(v), int'(rd_exp));
            end
        end
        wr_en = 1'b0;
        peek(2'd1, v);
        chk({tag, " R4 flag not yet at 8*D"}, int'(v[0]), 0);
        @(posedge clk); @(negedge clk);
        peek(2'd1, v);
        chk({tag, " R4 flag at 8*D+1"}, int'(v[0]), 1);
        chk({tag, " R5 irq"}, int'(irq), int'(exp_irq));
        chk({tag, " R1 eight sck rises"}, rises, 8);
        for (int i = 0; i < 8; i++) eseq[i] = lsb ? tx[i] : tx[7 - i];
        chk({tag, " R3 R2 mosi order"}, int'(mseq), int'(eseq));
        chk({tag, " R2 sck idle"}, int'(sck), 0);
        peek(2'd2, v);
        chk({tag, " R1 R3 received byte"}, int'(v), int'(sb));
    endtask

    // Main sequence of checks.
    initial begin
        logic [7:0] v, tx, sb;
        int k;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; miso = 1'b0;
        s_idx = 0; rises = 0; s_byte = '0; s_lsb = 0; mseq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R11 reset state
        peek(2'd0, v); chk("R11 control after reset", int'(v), 0);
        peek(2'd1, v); chk("R11 status after reset", int'(v), 0);
        chk("R11 sck after reset", int'(sck), 0);
        chk("R11 mosi after reset", int'(mosi), 0);
        chk("R11 irq after reset", int'(irq), 0);
        chk("R10 ss_n after reset", int'(ss_n), 1);

        // R10 select output
        bus_wr(2'd3, 8'h00);
        chk("R10 ss_n low", int'(ss_n), 0);
        peek(2'd3, v); chk("R10 select readback", int'(v[0]), 0);

        // R9 disabled and non-master writes start nothing
        rises = 0;
        bus_wr(2'd0, 8'h02);
        bus_wr(2'd2, 8'h5A);
        repeat (300) @(posedge clk);
        @(negedge clk);
        peek(2'd1, v); chk("R9 no flag when disabled", int'(v), 0);
        bus_wr(2'd0, 8'h01);
        bus_wr(2'd2, 8'h5A);
        repeat (300) @(posedge clk);
        @(negedge clk);
        peek(2'd1, v); chk("R9 no flag when not master", int'(v), 0);
        chk("R9 no sck edges", rises, 0);

        // R4 R3 sweep over every rate code, both speeds, both orders
        k = 0;
        for (int dbl = 0; dbl < 2; dbl++) begin
            for (int rate = 0; rate < 4; rate++) begin
                for (int lsb = 0; lsb < 2; lsb++) begin
                    tx = 8'(8'hA5 ^ (k * 37));
                    sb = 8'(8'h3C + k * 53);
                    bus_wr(2'd0, mk_ctrl(lsb[0], rate, dbl[0], 1'b1));
                    run_xfer(tx, sb, lsb[0], divisor(rate, dbl[0]), 1'b1, -1, 8'h00,
                             -1, 8'h00, $sformatf("sweep d%0d r%0d l%0d", dbl, rate, lsb));
                    clear_flags();
                    chk("R5 irq drops with flag", int'(irq), 0);
                    k++;
                end
            end
        end

        // R5 interrupt disabled: flag still set, no request
        bus_wr(2'd0, mk_ctrl(1'b0, 0, 1'b1, 1'b0));
        run_xfer(8'h81, 8'h7E, 1'b0, 2, 1'b0, -1, 8'h00, -1, 8'h00, "irq off");

        // R8 a data access alone does not clear the flag
        bus_rd(2'd2, v);
        peek(2'd1, v); chk("R8 flag kept without status read", int'(v[0]), 1);
        clear_flags();

        // R6 collision write during shift
        bus_wr(2'd0, mk_ctrl(1'b0, 0, 1'b0, 1'b0));
        run_xfer(8'hC3, 8'h96, 1'b0, 4, 1'b0, 16, 8'hFF, -1, 8'h00, "collision");
        peek(2'd1, v); chk("R6 collision flag set", int'(v[1:0]), 3);
        clear_flags();

        // R7 read buffer holds previous byte during the next transfer
        bus_wr(2'd0, mk_ctrl(1'b1, 0, 1'b0, 1'b0));
        run_xfer(8'h12, 8'hE7, 1'b1, 4, 1'b0, -1, 8'h00, -1, 8'h00, "buffer A");
        bus_rd(2'd1, v);
        bus_rd(2'd2, v); chk("R7 first byte read", int'(v), 8'hE7);
        run_xfer(8'h34, 8'h19, 1'b1, 4, 1'b0, -1, 8'h00, 20, 8'hE7, "buffer B");
        clear_flags();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule